// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

This block controls a three-wire serial configuration EEPROM with 16-bit words. Two part sizes are supported: a 64-word part addressed with 6 bits and a 256-word part addressed with 8 bits. When reset is released, the block reads the first 64 bytes of the part on its own, word by word. It copies the identification and bus-latency fields into shadow registers, and a bus configuration space presents those registers. A flag shows when the shadow registers are valid.

Once the load has finished, a host can read or write single words through a request/acknowledge command port. Before the first write after reset, the block sends a write-enable command once. After each write, it holds chip select high and waits for the part to report ready before it starts any other access.

Every serial timing window is given in nanoseconds and converted to whole system-clock cycles, rounded up. This keeps the serial clock, setup, hold and data-valid delays within the part's limits for any system clock period.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While reset is low and at the first edges after it, `ee_cs`, `ee_sk`, `ee_di` and `load_done` are 0. After reset is released, the load starts with no host action.
- R2: A read frame is a start bit 1, opcode `10`, then the word address MSB first, then 17 clocks. The address is 6 bits when `big_part`=0 and 8 bits when `big_part`=1. The first of the 17 clocks returns a dummy 0, and the other 16 return data MSB first. The part takes `ee_di` on the rising edge of `ee_sk`.
- R3: The load reads words 0 to LOAD_WORDS-1 (32 words, 64 bytes) exactly once, in that order. `load_done` then rises and stays 1 until reset.
- R4: Shadow mapping is as follows. Word 0 goes to `ven_id`, word 1 to `dev_id`, word 2 to `sub_ven_id` and word 3 to `sub_id`. Word 4 bits 15:8 go to `max_lat` and bits 7:0 to `min_gnt`. None of them changes after `load_done`, even when the host writes those words.
- R5: The high phase of `ee_sk` lasts HI = ceil(max(DIH_NS, ceil(SK_MIN_NS/2)) / CLK_NS) cycles. The low phase lasts LO = ceil(max(DIS_NS, CSS_NS, ceil(SK_MIN_NS/2), DOD_NS − HI·CLK_NS) / CLK_NS) cycles.
- R6: `ee_cs` rises LO cycles before the first `ee_sk` rise. `ee_sk` is high only while `ee_cs` is high. `ee_di` changes only while `ee_sk` is low, so it is set up LO cycles before each rise and held HI cycles after it.
- R7: `ee_do` is sampled HI+LO cycles after the rising edge that launched the bit, which is never less than DOD_NS.
- R8: A host request (`cmd_req`, `cmd_wr`, `cmd_addr`, `cmd_wdata`) is not taken while `load_done`=0. Every command finishes with a one-cycle `cmd_ack`. For a read, `cmd_rdata` holds the word when `cmd_ack` is high. The host drops `cmd_req` in the cycle after `cmd_ack`.
- R9: Before the first write after reset, the block sends a write-enable frame: start 1, opcode `00`, address whose top two bits are `11` and the rest 0. A write frame is start 1, opcode `01`, address, then 16 data bits MSB first.
- R10: After a write frame, `ee_cs` drops, then rises again while `ee_sk` stays low. `ee_do` is polled until it reads 1, and only then is `cmd_ack` given.
- R11: Between any two frames `ee_cs` stays low for at least HI+LO cycles, one serial clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low host bus reset; the load starts when it is released |
| big_part | input | 1 | Chip type: 0 selects 6-bit addressing, 1 selects 8-bit addressing |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |
| ven_id | output | 16 | Shadow vendor identifier |
| dev_id | output | 16 | Shadow device identifier |
| sub_ven_id | output | 16 | Shadow subsystem vendor identifier |
| sub_id | output | 16 | Shadow subsystem identifier |
| max_lat | output | 8 | Shadow maximum latency |
| min_gnt | output | 8 | Shadow minimum grant |
| load_done | output | 1 | Shadow registers are valid |
| cmd_req | input | 1 | Host command request |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Host word address; only the low 6 bits are used when `big_part`=0 |
| cmd_wdata | input | 16 | Host write data |
| cmd_ack | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | 16 | Host read data, valid with `cmd_ack` |

## Verification
The bench builds the block with CLK_NS=20, SK_MIN_NS=80, CSS_NS=20, DIS_NS=40, DIH_NS=40 and DOD_NS=100. This gives a 3-cycle low phase and a 2-cycle high phase, so a frame is short enough to sweep every word address of both part sizes. The bench's EEPROM model changes its data output 90 ns after each rising edge. A sample taken even one cycle early would therefore read stale data, which puts the R7 delay rule within reach of the data checks. The model accepts writes only after a write-enable frame and reports busy for 40 cycles after each write, so the write-enable and ready-polling paths show up in the readback and acknowledge timing.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int CLK_NS     = 20,
  parameter int SK_MIN_NS  = 1000,
  parameter int CSS_NS     = 200,
  parameter int DIS_NS     = 400,
  parameter int DIH_NS     = 400,
  parameter int DOD_NS     = 2000,
  parameter int LOAD_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_part,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic [15:0] ven_id,
  output logic [15:0] dev_id,
  output logic [15:0] sub_ven_id,
  output logic [15:0] sub_id,
  output logic [7:0]  max_lat,
  output logic [7:0]  min_gnt,
  output logic        load_done,
  input  logic        cmd_req,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        cmd_ack,
  output logic [15:0] cmd_rdata
);

  localparam int HALF_NS = (SK_MIN_NS + 1) / 2;
  localparam int HI_NS   = (DIH_NS > HALF_NS) ? DIH_NS : HALF_NS;
  localparam int HI_RAW  = (HI_NS + CLK_NS - 1) / CLK_NS;
  localparam int HI_CYC  = (HI_RAW < 1) ? 1 : HI_RAW;
  localparam int LO_A    = (DIS_NS > HALF_NS) ? DIS_NS : HALF_NS;
  localparam int LO_B    = (CSS_NS > LO_A) ? CSS_NS : LO_A;
  localparam int LO_C    = (DOD_NS > HI_CYC * CLK_NS) ? DOD_NS - HI_CYC * CLK_NS : 0;
  localparam int LO_NS   = (LO_C > LO_B) ? LO_C : LO_B;
  localparam int LO_RAW  = (LO_NS + CLK_NS - 1) / CLK_NS;
  localparam int LO_CYC  = (LO_RAW < 1) ? 1 : LO_RAW;
  localparam int GAP_CYC = LO_CYC + HI_CYC;
  localparam int TW      = $clog2(GAP_CYC + 1);
  localparam int TXW     = 27;
  localparam int IW      = $clog2(LOAD_WORDS);

  typedef enum logic [1:0] {ST_GAP, ST_LO, ST_HI, ST_POLL} st_t;
  typedef enum logic [1:0] {K_RD, K_EWEN, K_WR} kind_t;

  st_t            st;
  kind_t          kind, nk;
  logic [TW-1:0]  tmr;
  logic [4:0]     bits, nbits;
  logic [TXW-1:0] tx, ntx;
  logic [15:0]    rx;
  logic [IW-1:0]  ld_idx;
  logic           ewen_ok, wr_pend, poll_pend, host_busy;
  logic [7:0]     h_addr;
  logic [15:0]    h_data;
  logic           gap_ok, go_frame, go_poll;

  function automatic logic [TXW-1:0] pack(input logic [2:0] op, input logic [7:0] a,
                                          input logic [15:0] d, input logic big);
    return big ? {op, a, d} : {op, a[5:0], d, 2'b00};
  endfunction

  assign ee_cs  = (st != ST_GAP);
  assign ee_sk  = (st == ST_HI);
  assign ee_di  = (st == ST_LO || st == ST_HI) && tx[TXW-1];
  assign gap_ok = (st == ST_GAP) && (tmr == TW'(GAP_CYC));

  always_comb begin
    go_frame = 1'b0;
    go_poll  = 1'b0;
    nk       = K_RD;
    ntx      = '0;
    nbits    = '0;
    if (gap_ok) begin
      if (poll_pend) begin
        go_poll = 1'b1;
      end else if (wr_pend && !ewen_ok) begin
        go_frame = 1'b1;
        nk       = K_EWEN;
        ntx      = pack(3'b100, big_part ? 8'hC0 : 8'h30, 16'h0000, big_part);
        nbits    = big_part ? 5'd11 : 5'd9;
      end else if (wr_pend) begin
        go_frame = 1'b1;
        nk       = K_WR;
        ntx      = pack(3'b101, h_addr, h_data, big_part);
        nbits    = big_part ? 5'd27 : 5'd25;
      end else if (!load_done) begin
        go_frame = 1'b1;
        ntx      = pack(3'b110, 8'(ld_idx), 16'h0000, big_part);
        nbits    = big_part ? 5'd28 : 5'd26;
      end else if (host_busy) begin
        go_frame = 1'b1;
        ntx      = pack(3'b110, h_addr, 16'h0000, big_part);
        nbits    = big_part ? 5'd28 : 5'd26;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_GAP;
      kind       <= K_RD;
      tmr        <= '0;
      bits       <= '0;
      tx         <= '0;
      rx         <= '0;
      ld_idx     <= '0;
      ewen_ok    <= 1'b0;
      wr_pend    <= 1'b0;
      poll_pend  <= 1'b0;
      host_busy  <= 1'b0;
      h_addr     <= '0;
      h_data     <= '0;
      load_done  <= 1'b0;
      cmd_ack    <= 1'b0;
      cmd_rdata  <= '0;
      ven_id     <= '0;
      dev_id     <= '0;
      sub_ven_id <= '0;
      sub_id     <= '0;
      max_lat    <= '0;
      min_gnt    <= '0;
    end else begin
      cmd_ack <= 1'b0;
      if (load_done && !host_busy && cmd_req && !cmd_ack) begin
        host_busy <= 1'b1;
        h_addr    <= cmd_addr;
        h_data    <= cmd_wdata;
        wr_pend   <= cmd_wr;
      end
      case (st)
        ST_GAP: begin
          if (go_poll) begin
            st  <= ST_POLL;
            tmr <= '0;
          end else if (go_frame) begin
            st   <= ST_LO;
            tmr  <= '0;
            kind <= nk;
            tx   <= ntx;
            bits <= nbits;
          end else if (tmr != TW'(GAP_CYC)) begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_LO: begin
          if (tmr == TW'(LO_CYC - 1)) begin
            rx  <= {rx[14:0], ee_do};
            st  <= ST_HI;
            tmr <= '0;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_HI: begin
          if (tmr == TW'(HI_CYC - 1)) begin
            tmr  <= '0;
            tx   <= tx << 1;
            bits <= bits - 5'd1;
            if (bits == 5'd1) begin
              st <= ST_GAP;
              case (kind)
                K_RD: begin
                  if (!load_done) begin
                    case (ld_idx)
                      IW'(0): ven_id     <= rx;
                      IW'(1): dev_id     <= rx;
                      IW'(2): sub_ven_id <= rx;
                      IW'(3): sub_id     <= rx;
                      IW'(4): begin
                        max_lat <= rx[15:8];
                        min_gnt <= rx[7:0];
                      end
                      default: ;
                    endcase
                    if (ld_idx == IW'(LOAD_WORDS - 1)) load_done <= 1'b1;
                    else ld_idx <= ld_idx + IW'(1);
                  end else begin
                    cmd_rdata <= rx;
                    cmd_ack   <= 1'b1;
                    host_busy <= 1'b0;
                  end
                end
                K_EWEN: ewen_ok <= 1'b1;
                default: begin
                  wr_pend   <= 1'b0;
                  poll_pend <= 1'b1;
                end
              endcase
            end else begin
              st <= ST_LO;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        default: begin
          if (tmr == TW'(LO_CYC - 1)) begin
            if (ee_do) begin
              poll_pend <= 1'b0;
              host_busy <= 1'b0;
              cmd_ack   <= 1'b1;
              st        <= ST_GAP;
              tmr       <= '0;
            end
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
      endcase
    end
  end

  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs); // R6
  AST_DI_STEADY_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> $stable(ee_di)); // R6
  AST_NO_ACK_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cmd_ack |-> load_done); // R8
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_ack |=> !cmd_ack); // R8
  AST_LOAD_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) load_done |=> load_done); // R3
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> $stable({ven_id, dev_id, sub_ven_id, sub_id, max_lat, min_gnt})); // R4
  AST_WR_ACK_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && $past(st == ST_POLL)) |-> $past(ee_do)); // R10
  AST_CS_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_cs) |=> !ee_cs); // R11

endmodule

// File: tb/sim_eeprom_cfg_loader.sv
`timescale 1ns/1ps
module sim_eeprom_cfg_loader;
  localparam int CLK_NS = 20, SK_MIN_NS = 80, CSS_NS = 20, DIS_NS = 40, DIH_NS = 40, DOD_NS = 100;
  localparam int NWORDS = 32, BUSY = 40;
  localparam int HALF   = (SK_MIN_NS + 1) / 2;
  localparam int E_HI   = ((DIH_NS > HALF ? DIH_NS : HALF) + CLK_NS - 1) / CLK_NS;
  localparam int M1     = DIS_NS > CSS_NS ? DIS_NS : CSS_NS;
  localparam int M2     = M1 > HALF ? M1 : HALF;
  localparam int M3     = DOD_NS - E_HI * CLK_NS;
  localparam int E_LO   = ((M3 > M2 ? M3 : M2) + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0, big = 0;
  logic ee_cs, ee_sk, ee_di, ee_do, load_done, cmd_req, cmd_wr, cmd_ack;
  logic [7:0] cmd_addr, max_lat, min_gnt;
  logic [15:0] cmd_wdata, cmd_rdata, ven_id, dev_id, sub_ven_id, sub_id;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_NS / 2) clk = ~clk;

  eeprom_cfg_loader #(.CLK_NS(CLK_NS), .SK_MIN_NS(SK_MIN_NS), .CSS_NS(CSS_NS), .DIS_NS(DIS_NS),
    .DIH_NS(DIH_NS), .DOD_NS(DOD_NS), .LOAD_WORDS(NWORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .big_part(big), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .ven_id(ven_id), .dev_id(dev_id), .sub_ven_id(sub_ven_id), .sub_id(sub_id),
    .max_lat(max_lat), .min_gnt(min_gnt), .load_done(load_done), .cmd_req(cmd_req),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .cmd_rdata(cmd_rdata));

  function automatic logic [15:0] pat(input int a);
    int v;
    v = a * 40503 + 4660;
    return v[15:0] ^ {v[7:0], v[15:8]};
  endfunction

  // EEPROM model, evaluated on falling clock edges
  logic [15:0] mem [256];
  logic [15:0] shreg, m_wd;
  logic [7:0]  m_addr;
  logic [2:0]  m_hdr;
  logic cs_q, sk_q, di_q, rd_mode, do_r, pend, m_ewen, first;
  int bc, busy_cnt, lag, rd_frames, frame_bad, aw;
  int lo_run, hi_run, gap_run = 1000;
  int lo_min = 1000, hi_min = 1000, gap_min = 1000, setup_min = 1000, di_bad = 0;

  assign ee_do = rd_mode ? do_r : (busy_cnt == 0);

  always @(negedge clk) begin
    aw = big ? 8 : 6;
    if (!rst_n) begin
      for (int a = 0; a < 256; a++) mem[a] = pat(a);
      bc = 0; rd_mode = 0; do_r = 1; pend = 0; busy_cnt = 0; lag = 0; m_ewen = 0;
      rd_frames = 0; frame_bad = 0; m_hdr = 0; m_addr = 0; m_wd = 0; shreg = 0;
      cs_q = 0; sk_q = 0; di_q = 0; first = 0; lo_run = 0; hi_run = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (lag > 0) begin
        lag--;
        if (lag == 0) do_r = pend;
      end
      if (ee_cs && !cs_q) begin
        bc = 0; rd_mode = 0; m_hdr = 0; m_addr = 0; m_wd = 0; first = 1; lo_run = 0;
        if (gap_run < gap_min) gap_min = gap_run;
      end
      if (!ee_cs && cs_q) begin
        if (m_hdr[1:0] == 2'b01 && bc == 3 + aw + 16 && m_ewen) begin
          mem[m_addr] = m_wd;
          busy_cnt = BUSY;
        end
        if (m_hdr[1:0] == 2'b00 && bc == 3 + aw &&
            (big ? m_addr[7:6] == 2'b11 : m_addr[5:4] == 2'b11)) m_ewen = 1;
        rd_mode = 0;
        gap_run = 0;
      end
      if (ee_cs && ee_sk && !sk_q) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (first && lo_run < setup_min) setup_min = lo_run;
        bc++;
        if (bc <= 3) m_hdr = {m_hdr[1:0], ee_di};
        else if (bc <= 3 + aw) m_addr = {m_addr[6:0], ee_di};
        else m_wd = {m_wd[14:0], ee_di};
        if (bc == 3 && !m_hdr[2]) frame_bad++;
        if (bc == 3 + aw && m_hdr[1:0] == 2'b10) begin
          rd_mode = 1; shreg = mem[m_addr]; pend = 0; lag = 4; rd_frames++;
        end else if (rd_mode) begin
          pend = shreg[15]; shreg = {shreg[14:0], 1'b0}; lag = 4;
        end
        lo_run = 0; hi_run = 0; first = 0;
      end
      if (ee_cs && !ee_sk && sk_q && hi_run < hi_min) hi_min = hi_run;
      if (ee_sk) hi_run++;
      else if (ee_cs) lo_run++;
      if (!ee_cs) gap_run++;
      if (ee_cs && ee_sk && sk_q && ee_di != di_q) di_bad++;
      cs_q = ee_cs; sk_q = ee_sk; di_q = ee_di;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input int a, input logic [15:0] d,
                         output logic [15:0] q, output int busy_at_ack);
    @(negedge clk);
    cmd_req = 1; cmd_wr = wr; cmd_addr = 8'(a); cmd_wdata = d;
    do @(negedge clk); while (!cmd_ack);
    q = cmd_rdata;
    busy_at_ack = busy_cnt;
    cmd_req = 0;
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int bsy, pre, words, wa;
    logic [15:0] wdat;
    cmd_req = 0; cmd_wr = 0; cmd_addr = 0; cmd_wdata = 0;
    for (int p = 0; p < 2; p++) begin
      big = p[0];
      rst_n = 0;
      repeat (4) @(negedge clk);
      chk("R1 serial pins idle in reset", {29'd0, ee_cs, ee_sk, ee_di}, 0);
      chk("R1 load_done low in reset", load_done, 0);
      rst_n = 1;
      cmd_req = 1; cmd_wr = 0; cmd_addr = 8'd7;
      pre = 0;
      do begin
        @(negedge clk);
        if (cmd_ack) pre++;
      end while (!load_done);
      chk("R8 no ack before load_done", pre, 0);
      chk("R3 load read count", rd_frames, NWORDS);
      chk("R2 start bit of every frame", frame_bad, 0);
      chk("R4 vendor id", ven_id, pat(0));
      chk("R4 device id", dev_id, pat(1));
      chk("R4 subsystem vendor id", sub_ven_id, pat(2));
      chk("R4 subsystem id", sub_id, pat(3));
      chk("R4 max latency", max_lat, {24'd0, pat(4) >> 8});
      chk("R4 min grant", min_gnt, {24'd0, pat(4) & 16'h00ff});
      do @(negedge clk); while (!cmd_ack);
      chk("R8 held-off read data", cmd_rdata, pat(7));
      cmd_req = 0;
      words = big ? 256 : 64;
      for (int a = 0; a < words; a++) begin
        host_op(1'b0, a, 16'h0, q, bsy);
        chk("R2 R7 host read sweep", q, mem[a]);
      end
      for (int k = 0; k < 4; k++) begin
        wa = (k < 2) ? k : ((k == 2) ? (big ? 200 : 45) : words - 1);
        wdat = 16'hC0DE ^ 16'(k * 4369 + p * 17);
        host_op(1'b1, wa, wdat, q, bsy);
        chk("R10 write ack only after ready", bsy, 0);
        chk("R9 write enable seen", m_ewen, 1);
        host_op(1'b0, wa, 16'h0, q, bsy);
        chk("R9 write readback", q, wdat);
      end
      chk("R4 vendor id frozen after write", ven_id, pat(0));
      chk("R4 device id frozen after write", dev_id, pat(1));
      chk("R3 load_done stays high", load_done, 1);
    end
    chk("R5 sk high width", hi_min, E_HI);
    chk("R5 sk low width", lo_min, E_LO);
    chk("R6 cs setup before first sk", setup_min, E_LO);
    chk("R6 di stable while sk high", di_bad, 0);
    chk("R11 cs low gap", gap_min >= E_LO + E_HI, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule